// File: doc/BRIEF.md
# PPS capture and period monitor

The block watches an external once-per-second timing pulse and measures, in cycles of the streaming clock, the distance between consecutive pulses. It compares each measured period against a programmable expected count and keeps a sticky "stable" verdict that covers every period seen since software last read the status word. A toggle bit that inverts on each pulse lets software see that pulses keep arriving even when it polls slowly. A third register returns the number of cycles elapsed since the latest pulse, frozen at the moment of the read.

The input passes through a capture flop (on the rising or the falling clock edge, selectable) and a second synchronizing flop. Its rising transition produces a one-cycle `pps_pulse` strobe for downstream logic. The period counter is sized from the nominal clock frequency. It saturates when pulses stop, so a missing pulse shows up as a mismatch.

Top module: `pps_period_monitor`

## Requirements
- R1: After reset, word 0 reads 0x00000000, word 1 reads the expected-count reset value (equal to CLK_HZ) with bit 31 clear, and `pps_pulse` is low.
- R2: Each rising transition of `pps_in` that is held for at least two clock cycles produces exactly one `pps_pulse` that is one cycle wide.
- R3: Word 0 bits [29:0] hold the cycle count between the two most recent pulses, zero-extended from a CNT_W = ceil(log2(CLK_HZ)) bit counter.
- R4: Word 0 bit 31 inverts once per detected pulse and starts at 0.
- R5: Word 0 bit 30 (stable) reads 1 only if every period measured since the previous read of word 0 equalled the expected count. One mismatch makes it read 0 until word 0 is read again.
- R6: After reset, stable reads 0 until at least one full period has been measured. After that, a read of word 0 re-arms stable to 1 for the next window.
- R7: Word 1 is read/write: bits [29:0] hold the expected count, bit 31 holds the edge select, and bit 30 reads 0.
- R8: With word 1 bit 31 = 1, `pps_in` is captured on the falling clock edge instead of the rising edge, and measured periods remain exact.
- R9: Word 2 returns the number of cycles since the last pulse, sampled at the read. Two reads taken k cycles apart in the same period differ by exactly k.
- R10: With no pulse, the cycle counter saturates at 2^CNT_W-1. Word 2 then reads that value, stable is cleared, and the next pulse reports that value as the period.
- R11: Writes to word 0 and word 2 change no register contents.
- R12: `reg_rdata` holds the addressed word from the clock edge at which `reg_rd` is sampled high, and a read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Streaming clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pps_in | input | 1 | External pulse-per-second input, asynchronous |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_rdata | output | 32 | Registered read data |
| pps_pulse | output | 1 | One-cycle strobe per detected pulse |

## Verification
The bench makes the stable flag sticky across a window that contains one long period followed by a correct one. A design that judges only the latest period would report stable there. It checks that stable stays low straight after reset even when a read happens before the first full period; a design that re-arms on that read would claim stability with nothing measured. It stops the pulses until the counter saturates, and checks both the elapsed reading and the following period. A wrapping counter would report a small, possibly matching, value instead. It also switches the capture edge and changes the expected count, confirming that periods stay exact and that writes to the read-only words leave everything untouched.

// File: rtl/pps_mon_pkg.sv
// Package: pps_mon_pkg
// Shared register word layouts and word addresses of the PPS period monitor.
// Assumes a 32-bit register data path with 30-bit count fields.
package pps_mon_pkg;

    localparam int DATA_W  = 32;
    localparam int FIELD_W = 30;

    localparam logic [1:0] ADDR_STATUS  = 2'd0;
    localparam logic [1:0] ADDR_CONFIG  = 2'd1;
    localparam logic [1:0] ADDR_ELAPSED = 2'd2;

    // Word 0 layout, bit positions are seen by software
    typedef struct packed {
        logic               toggle;
        logic               stable;
        logic [FIELD_W-1:0] period;
    } status_word_t;

    // Word 1 layout
    typedef struct packed {
        logic               fall_edge;
        logic               spare;
        logic [FIELD_W-1:0] expected;
    } config_word_t;

endpackage

// File: rtl/pps_sampler.sv
// Module: pps_sampler
// Captures the asynchronous pulse input on the selected clock edge, passes it
// through a second flop and detects its rising transition as a one-cycle strobe.
// Assumes the pulse stays high for at least two clock cycles.
module pps_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_in,
    input  logic fall_sel,
    output logic strobe
);

    logic cap_rise;
    logic cap_fall;
    logic sync_q;
    logic prev_q;

    // First capture flop on the rising clock edge
    always_ff @(posedge clk) begin
        if (!rst_n) cap_rise <= 1'b0;
        else        cap_rise <= pps_in;
    end

    // First capture flop on the falling clock edge
    always_ff @(negedge clk) begin
        if (!rst_n) cap_fall <= 1'b0;
        else        cap_fall <= pps_in;
    end

    // Second synchronizer stage and history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= fall_sel ? cap_fall : cap_rise;
            prev_q <= sync_q;
        end
    end

    assign strobe = sync_q & ~prev_q;

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

endmodule

// File: rtl/pps_period_tracker.sv
// Module: pps_period_tracker
// Counts cycles between strobes, captures each period, keeps the sticky
// stable verdict and the per-pulse toggle. The counter saturates when pulses
// stop. Assumes CNT_W <= FIELD_W.
module pps_period_tracker
    import pps_mon_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    input  logic [FIELD_W-1:0] expected,
    input  logic               status_read,
    output logic [CNT_W-1:0]   period,
    output logic [CNT_W-1:0]   elapsed,
    output logic               stable,
    output logic               toggle
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period_q;
    logic             toggle_q;
    logic             seen_first;
    logic             full_done;
    logic             stable_q;
    logic             stable_n;
    logic             cnt_max;
    logic             match;

    assign cnt_max = (cnt == CNT_MAX);
    assign match   = (FIELD_W'(cnt) == expected);

    // Cycle counter, period capture and toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            period_q   <= '0;
            toggle_q   <= 1'b0;
            seen_first <= 1'b0;
            full_done  <= 1'b0;
        end else begin
            if (strobe) begin
                cnt        <= CNT_W'(1);
                period_q   <= cnt;
                toggle_q   <= ~toggle_q;
                seen_first <= 1'b1;
                if (seen_first) full_done <= 1'b1;
            end else if (!cnt_max) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Next value of the sticky stable verdict
    always_comb begin
        stable_n = stable_q;
        if (status_read && full_done) stable_n = 1'b1;
        if (strobe && seen_first)     stable_n = full_done ? (stable_n & match) : match;
        if (cnt_max && seen_first)    stable_n = 1'b0;
    end

    // Stable verdict register
    always_ff @(posedge clk) begin
        if (!rst_n) stable_q <= 1'b0;
        else        stable_q <= stable_n;
    end

    assign period  = period_q;
    assign elapsed = cnt;
    assign stable  = stable_q;
    assign toggle  = toggle_q;

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !cnt_max) |=> (cnt == $past(cnt) + 1'b1));

    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && cnt_max) |=> (cnt == CNT_MAX));

    // R4
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (toggle_q != $past(toggle_q)));

    // R4
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(toggle_q));

    // R5
    mismatch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && seen_first && !match) |=> !stable_q);

    // R3
    period_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (period_q == $past(cnt)) && (cnt == CNT_W'(1)));

endmodule

// File: rtl/pps_mon_regs.sv
// Module: pps_mon_regs
// Three-word register file: status (read only), configuration (read/write)
// and elapsed count (read only). Read data is registered. Assumes one-cycle
// read and write strobes.
module pps_mon_regs
    import pps_mon_pkg::*;
#(
    parameter int                 CNT_W     = 28,
    parameter logic [FIELD_W-1:0] EXP_RESET = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic               reg_rd,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [CNT_W-1:0]   period,
    input  logic [CNT_W-1:0]   elapsed,
    input  logic               stable,
    input  logic               toggle,
    output logic [FIELD_W-1:0] expected,
    output logic               fall_sel,
    output logic               status_read
);

    config_word_t      cfg_q;
    config_word_t      cfg_wr;
    status_word_t      status_w;
    logic [DATA_W-1:0] rd_word;

    assign cfg_wr      = config_word_t'(reg_wdata);
    assign status_read = reg_rd && (reg_addr == ADDR_STATUS);

    // Configuration register, the spare bit always reads 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.fall_edge <= 1'b0;
            cfg_q.spare     <= 1'b0;
            cfg_q.expected  <= EXP_RESET;
        end else if (reg_wr && (reg_addr == ADDR_CONFIG)) begin
            cfg_q.fall_edge <= cfg_wr.fall_edge;
            cfg_q.spare     <= 1'b0;
            cfg_q.expected  <= cfg_wr.expected;
        end
    end

    // Pack the status word
    always_comb begin
        status_w.toggle = toggle;
        status_w.stable = stable;
        status_w.period = FIELD_W'(period);
    end

    // Select the addressed word
    always_comb begin
        case (reg_addr)
            ADDR_STATUS:  rd_word = DATA_W'(status_w);
            ADDR_CONFIG:  rd_word = DATA_W'(cfg_q);
            ADDR_ELAPSED: rd_word = DATA_W'(elapsed);
            default:      rd_word = '0;
        endcase
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_word;
    end

    assign expected = cfg_q.expected;
    assign fall_sel = cfg_q.fall_edge;

    // R7
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CONFIG) |=>
            (expected == $past(reg_wdata[FIELD_W-1:0])) && (fall_sel == $past(reg_wdata[DATA_W-1])));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_CONFIG) |=> ($stable(expected) && $stable(fall_sel)));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

endmodule

// File: rtl/pps_period_monitor.sv
// Module: pps_period_monitor
// Top level: pulse sampler, period tracker and register file. Single clock
// domain; the counter width is derived from the nominal clock frequency.
module pps_period_monitor
    import pps_mon_pkg::*;
#(
    parameter int CLK_HZ = 200_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pps_in,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pps_pulse
);

    localparam int                 CNT_W     = $clog2(CLK_HZ);
    localparam logic [FIELD_W-1:0] EXP_RESET = FIELD_W'(CLK_HZ);

    logic               strobe;
    logic               fall_sel;
    logic               status_read;
    logic [FIELD_W-1:0] expected;
    logic [CNT_W-1:0]   period;
    logic [CNT_W-1:0]   elapsed;
    logic               stable;
    logic               toggle;

    pps_sampler u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .pps_in   (pps_in),
        .fall_sel (fall_sel),
        .strobe   (strobe)
    );

    pps_period_tracker #(.CNT_W(CNT_W)) u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe      (strobe),
        .expected    (expected),
        .status_read (status_read),
        .period      (period),
        .elapsed     (elapsed),
        .stable      (stable),
        .toggle      (toggle)
    );

    pps_mon_regs #(.CNT_W(CNT_W), .EXP_RESET(EXP_RESET)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rd      (reg_rd),
        .reg_rdata   (reg_rdata),
        .period      (period),
        .elapsed     (elapsed),
        .stable      (stable),
        .toggle      (toggle),
        .expected    (expected),
        .fall_sel    (fall_sel),
        .status_read (status_read)
    );

    assign pps_pulse = strobe;

endmodule

// File: tb/pps_period_monitor_tb.sv
// Bench: directed scenarios against pps_period_monitor with a 1 kHz nominal
// clock setting (10-bit counter) so that saturation is reachable.
module pps_period_monitor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TB_HZ      = 1000;
    localparam int SAT        = 1023;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pps_in;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        pps_pulse;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int rises = 0;
    int pulse_cycles = 0;
    logic gen_en = 1'b0;
    int gen_period = 100;

    pps_period_monitor #(.CLK_HZ(TB_HZ)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pps_in    (pps_in),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .pps_pulse (pps_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog and cycle counter
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Count cycles in which the output strobe is high
    always @(negedge clk) if (pps_pulse === 1'b1) pulse_cycles <= pulse_cycles + 1;

    // Pulse generator: high for 4 cycles, period latched at each rise
    initial begin
        int lowlen;
        pps_in = 1'b0;
        forever begin
            @(posedge clk); #1;
            if (gen_en) begin
                pps_in = 1'b1;
                rises = rises + 1;
                lowlen = gen_period - 4;
                repeat (4) @(posedge clk);
                #1 pps_in = 1'b0;
                repeat (lowlen - 1) @(posedge clk);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_rd = 1'b1;
        @(posedge clk); #1;
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    // Wait for n output strobes, then 10 quiet cycles
    task automatic wait_pulses(input int n);
        int seen = 0;
        while (seen < n) begin
            @(negedge clk);
            if (pps_pulse) seen++;
        end
        repeat (10) @(posedge clk);
    endtask

    function automatic logic [31:0] status(input int per, input logic st);
        return {logic'(rises % 2), st, 30'(per)};
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        check("R1 pps_pulse low", {31'd0, pps_pulse}, 32'd0);
        reg_read(2'd0, d);
        check("R1 word0 after reset", d, 32'd0);
        reg_read(2'd1, d);
        check("R1 word1 after reset", d, 32'(TB_HZ));
        reg_read(2'd3, d);
        check("R12 unused address reads 0", d, 32'd0);
    endtask

    task automatic t_first_periods;
        logic [31:0] d;
        reg_write(2'd1, 32'd100);
        reg_read(2'd1, d);
        check("R7 word1 readback", d, 32'd100);
        gen_period = 100;
        gen_en = 1'b1;
        wait_pulses(1);
        reg_read(2'd0, d);
        check("R6 stable low before full period", {30'd0, d[31:30]}, {30'd0, logic'(rises % 2), 1'b0});
        check("R4 toggle after first pulse", {31'd0, d[31]}, 32'd1);
        wait_pulses(1);
        reg_read(2'd0, d);
        check("R3 R5 first full period", d, status(100, 1'b1));
        reg_read(2'd0, d);
        check("R6 re-armed read", d, status(100, 1'b1));
    endtask

    task automatic t_sticky;
        logic [31:0] d;
        gen_period = 101;
        wait_pulses(2);
        gen_period = 100;
        wait_pulses(2);
        reg_read(2'd0, d);
        check("R5 sticky mismatch", d, status(100, 1'b0));
        wait_pulses(1);
        reg_read(2'd0, d);
        check("R5 window after read", d, status(100, 1'b1));
        check("R4 toggle parity", {31'd0, d[31]}, 32'(rises % 2));
    endtask

    task automatic t_elapsed;
        logic [31:0] a, b;
        reg_read(2'd2, a);
        repeat (20) @(posedge clk);
        reg_read(2'd2, b);
        check("R9 elapsed difference", b - a, 32'd22);
    endtask

    task automatic t_ignored_writes;
        logic [31:0] a, b;
        reg_read(2'd0, a);
        reg_write(2'd0, 32'hFFFF_FFFF);
        reg_write(2'd2, 32'hFFFF_FFFF);
        reg_read(2'd0, b);
        check("R11 word0 unaffected", b, {a[31], 1'b1, a[29:0]});
        reg_read(2'd1, b);
        check("R11 word1 unaffected", b, 32'd100);
    endtask

    task automatic t_fall_edge;
        logic [31:0] d;
        reg_write(2'd1, 32'h8000_0000 | 32'd100);
        reg_read(2'd1, d);
        check("R7 edge bit readback", d, 32'h8000_0064);
        wait_pulses(3);
        reg_read(2'd0, d);
        wait_pulses(2);
        reg_read(2'd0, d);
        check("R8 falling-edge period", d, status(100, 1'b1));
        reg_write(2'd1, 32'h7FFF_FFFF & 32'd150);
    endtask

    task automatic t_new_expected;
        logic [31:0] d;
        reg_write(2'd1, 32'hC000_0096);
        reg_read(2'd1, d);
        check("R7 spare bit reads 0", d, 32'h8000_0096);
        gen_period = 150;
        wait_pulses(3);
        reg_read(2'd0, d);
        wait_pulses(2);
        reg_read(2'd0, d);
        check("R5 new expected count", d, status(150, 1'b1));
    endtask

    task automatic t_saturate;
        logic [31:0] d;
        gen_en = 1'b0;
        repeat (1200) @(posedge clk);
        reg_read(2'd2, d);
        check("R10 elapsed saturates", d, 32'(SAT));
        reg_read(2'd0, d);
        check("R10 stable cleared while saturated", {31'd0, d[30]}, 32'd0);
        gen_en = 1'b1;
        wait_pulses(1);
        reg_read(2'd0, d);
        check("R10 saturated period", d, status(SAT, 1'b0));
        wait_pulses(2);
        reg_read(2'd0, d);
        check("R10 recovery", d, status(150, 1'b1));
    endtask

    task automatic t_pulse_width;
        check("R2 one strobe cycle per input pulse", 32'(pulse_cycles), 32'(rises));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        t_reset();
        t_first_periods();
        t_sticky();
        t_elapsed();
        t_ignored_writes();
        t_fall_edge();
        t_new_expected();
        t_saturate();
        t_pulse_width();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule